// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block keeps, for one function, a table of interrupt vectors and a packed bitmap of vectors that are waiting to be delivered. Software fills the table through a simple 32-bit register port. Each entry holds a 64-bit message address, a 32-bit message data word and a control word whose bit 0 masks that vector. Device logic asks for an interrupt by presenting a vector index. The block then either launches a message write on a valid/ready output, or, if the vector is masked, records the request in the bitmap. A masked request that is waiting is sent once the vector becomes unmasked.

All requests pass through the pending bitmap. Every accepted request sets its bit. A small arbiter takes the lowest-numbered bit whose vector is unmasked, clears that bit and reads the entry out of the table. The message appears on the output two clock edges after the request edge. Only one message is in flight at a time. The table words are held in three memories that can be inferred as block RAM. The mask bits and pending bits are held in flops, because the arbiter looks at all of them in the same cycle.

Top module: `msix_vec_ctrl`

## Requirements
- R1: NUM_VEC must lie between 1 and 2048, otherwise elaboration stops. The table occupies byte offsets 0 to 16*NUM_VEC-1. The bitmap starts at byte offset max(2048, 16*NUM_VEC), which is 2048 for the default of 8 vectors. The whole window, rounded up to a power of two of at least 4096 bytes, must fit in ADDR_W.
- R2: Entry v occupies 16 bytes at offset 16*v. Address low is at +0, address high at +4, data at +8 and control at +12. Only control bit 0 (the mask) is stored; the other control bits read as 0. Address bits [1:0] are ignored, so every access is a whole little-endian 32-bit word.
- R3: After reset, every vector's mask bit reads 1, the bitmap reads 0 and msg_valid is 0.
- R4: A vector counts as masked when fn_mask is 1 or when its own mask bit is 1.
- R5: A request is dropped, leaving no pending bit and sending no message, when req_idx >= NUM_VEC or when vec_inuse[req_idx] is 0.
- R6: A request to a masked vector sets its pending bit and sends no message. Vector v is bit v%32 of the bitmap dword at byte offset (bitmap base + 4*(v/32)).
- R7: A request to an unmasked vector in use, accepted at clock edge e0, makes msg_valid 1 after edge e0+2. msg_addr then equals {address high, address low} of that entry and msg_data equals its data word.
- R8: When a vector with a set pending bit becomes unmasked, through its own mask bit or through fn_mask, its message is sent and its pending bit reads 0 afterwards.
- R9: When several pending vectors are unmasked at the same time, they are sent in ascending vector order.
- R10: While msg_valid is 1 and msg_ready is 0, msg_valid, msg_addr and msg_data hold their values. Each accepted handshake carries exactly one message.
- R11: Writes into the bitmap region change nothing.
- R12: While msix_en is 0, requests are not recorded and no new message is started. Bits already pending are kept and are delivered once msix_en returns to 1.
- R13: reg_rdata holds the read value from the clock edge after reg_rd is sampled. A read that hits neither the table nor the bitmap returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msix_en | input | 1 | Function-level enable for the message mechanism |
| fn_mask | input | 1 | Function-wide mask applied to all vectors |
| vec_inuse | input | NUM_VEC | Per-vector flag set by the device for vectors it uses |
| req_vld | input | 1 | Interrupt request strobe, one request per cycle |
| req_idx | input | 11 | Vector index of the request |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| msg_valid | output | 1 | A message write is presented |
| msg_ready | input | 1 | The consumer takes the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
A pending or mask bit that is held wrongly appears in the next bitmap or control read. It also shows within two edges as a message that should not be sent, or as a message that never comes. A wrong arbiter choice shows as a payload that differs from the bench model on the first cycle msg_valid is high. A read port that goes stale shows as a read-back mismatch one cycle after the read. The bench keeps a model of the pending, mask and in-flight state and compares msg_valid, msg_addr, msg_data and every read result on each clock. Any fault therefore shows at the ports within three cycles of the event that causes it.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int MSIX_MAX_VEC = 2048;
  localparam int MSIX_IDX_W   = 11;

  typedef enum logic [1:0] {
    RG_NONE,
    RG_TBL,
    RG_CTRL,
    RG_PBA
  } rsel_e;

  function automatic int pow2_up(input int x);
    int p;
    p = 1;
    while (p < x) p = p * 2;
    return p;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/msix_tbl_store.sv
module msix_tbl_store #(
  parameter int NUM_VEC = 8,
  parameter int VW      = 3
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [1:0]       wr_word,
  input  logic [VW-1:0]    wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             sw_rd,
  input  logic [VW-1:0]    sw_idx,
  output logic [2:0][31:0] sw_q,
  input  logic             mg_rd,
  input  logic [VW-1:0]    mg_idx,
  output logic [2:0][31:0] mg_q
);
  // Word 0 = address low, 1 = address high, 2 = data. One RAM per word,
  // each with one write port and two registered read ports.
  for (genvar w = 0; w < 3; w++) begin : g_word
    logic [31:0] mem [NUM_VEC];
    logic [31:0] sw_r;
    logic [31:0] mg_r;

    always_ff @(posedge clk) begin
      if (wr_en && wr_word == 2'(w)) mem[wr_idx] <= wr_data;
      if (sw_rd) sw_r <= mem[sw_idx];
      if (mg_rd) mg_r <= mem[mg_idx];
    end

    assign sw_q[w] = sw_r;
    assign mg_q[w] = mg_r;
  end
endmodule

// File: rtl/msix_pend_arb.sv
module msix_pend_arb #(
  parameter int NUM_VEC = 8,
  parameter int VW      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [VW-1:0]      set_idx,
  input  logic [NUM_VEC-1:0] masked,
  input  logic               launch_ok,
  output logic [NUM_VEC-1:0] pend_q,
  output logic               pick_vld,
  output logic [VW-1:0]      pick_idx
);
  logic [NUM_VEC-1:0] ready_v;

  assign ready_v  = pend_q & ~masked;
  assign pick_vld = launch_ok && (|ready_v);

  // Lowest ready index wins (R9): scan downward, last hit is the smallest.
  always_comb begin
    pick_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (ready_v[i]) pick_idx = VW'(i);
    end
  end

  // A new request in the same cycle as the pick re-arms the bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      if (pick_vld) pend_q[pick_idx] <= 1'b0;
      if (set_en)   pend_q[set_idx]  <= 1'b1;
    end
  end
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADDR_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  msix_en,
  input  logic                  fn_mask,
  input  logic [NUM_VEC-1:0]    vec_inuse,
  input  logic                  req_vld,
  input  logic [MSIX_IDX_W-1:0] req_idx,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [63:0]           msg_addr,
  output logic [31:0]           msg_data
);
  localparam int VW        = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int TBL_BYTES = NUM_VEC * 16;
  localparam int PBA_OFF   = imax(2048, TBL_BYTES);
  localparam int PBA_DW    = (NUM_VEC + 31) / 32;
  localparam int PW        = (PBA_DW > 1) ? $clog2(PBA_DW) : 1;
  localparam int PBA_BYTES = (NUM_VEC / 8 + 1) * 8;
  localparam int WIN       = pow2_up(imax(4096, PBA_OFF + PBA_BYTES));

  // R1: reject illegal configurations at elaboration
  if (NUM_VEC < 1 || NUM_VEC > MSIX_MAX_VEC) begin : g_bad_count
    $error("NUM_VEC out of range 1..2048");
  end
  if ((64'd1 << ADDR_W) < 64'(WIN)) begin : g_bad_window
    $error("ADDR_W too narrow for the window");
  end

  // ---------------- address decode ----------------
  logic [31:0]   a32;
  logic          tbl_hit, pba_hit;
  logic [VW-1:0] a_idx;
  logic [1:0]    a_word;
  logic [PW-1:0] a_pdw;

  assign a32     = 32'(reg_addr);
  assign tbl_hit = a32 < 32'(TBL_BYTES);
  assign pba_hit = (a32 >= 32'(PBA_OFF)) && (a32 < 32'(PBA_OFF + 4 * PBA_DW));
  assign a_idx   = a32[VW+3:4];
  assign a_word  = a32[3:2];
  assign a_pdw   = PW'((a32 - 32'(PBA_OFF)) >> 2);

  // ---------------- mask bits ----------------
  logic [NUM_VEC-1:0] mask_q;
  logic [NUM_VEC-1:0] masked;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else if (reg_wr && tbl_hit && a_word == 2'd3) mask_q[a_idx] <= reg_wdata[0];
  end

  assign masked = mask_q | {NUM_VEC{fn_mask}};

  // ---------------- pending + arbitration ----------------
  logic [NUM_VEC-1:0] pend_q;
  logic               set_en, pick_vld, fetch_q, launch_ok;
  logic [VW-1:0]      pick_idx;

  assign set_en = req_vld && msix_en && (32'(req_idx) < 32'(NUM_VEC))
                  && vec_inuse[req_idx[VW-1:0]];
  assign launch_ok = msix_en && !fetch_q && !msg_valid;

  msix_pend_arb #(.NUM_VEC(NUM_VEC), .VW(VW)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .set_en   (set_en),
    .set_idx  (req_idx[VW-1:0]),
    .masked   (masked),
    .launch_ok(launch_ok),
    .pend_q   (pend_q),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  // ---------------- table storage ----------------
  logic [2:0][31:0] sw_q, mg_q;

  msix_tbl_store #(.NUM_VEC(NUM_VEC), .VW(VW)) u_store (
    .clk    (clk),
    .wr_en  (reg_wr && tbl_hit && a_word != 2'd3),
    .wr_word(a_word),
    .wr_idx (a_idx),
    .wr_data(reg_wdata),
    .sw_rd  (reg_rd && tbl_hit),
    .sw_idx (a_idx),
    .sw_q   (sw_q),
    .mg_rd  (pick_vld),
    .mg_idx (pick_idx),
    .mg_q   (mg_q)
  );

  // ---------------- message output stage ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_q   <= 1'b0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      fetch_q <= pick_vld;
      if (fetch_q) begin
        msg_valid <= 1'b1;
        msg_addr  <= {mg_q[1], mg_q[0]};
        msg_data  <= mg_q[2];
      end else if (msg_valid && msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  // ---------------- software read path ----------------
  logic [31:0] pba_w [PBA_DW];

  for (genvar k = 0; k < PBA_DW; k++) begin : g_pba
    for (genvar j = 0; j < 32; j++) begin : g_bit
      if (k * 32 + j < NUM_VEC) begin : g_live
        assign pba_w[k][j] = pend_q[k*32+j];
      end else begin : g_pad
        assign pba_w[k][j] = 1'b0;
      end
    end
  end

  rsel_e       sel_q;
  logic [1:0]  word_q;
  logic [31:0] aux_q;

  // R11: bitmap region has no write path at all
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= RG_NONE;
      word_q <= '0;
      aux_q  <= '0;
    end else if (reg_rd) begin
      word_q <= a_word;
      if (tbl_hit && a_word != 2'd3) begin
        sel_q <= RG_TBL;
      end else if (tbl_hit) begin
        sel_q <= RG_CTRL;
        aux_q <= {31'b0, mask_q[a_idx]};
      end else if (pba_hit) begin
        sel_q <= RG_PBA;
        aux_q <= pba_w[a_pdw];
      end else begin
        sel_q <= RG_NONE;
        aux_q <= '0;
      end
    end
  end

  always_comb begin
    reg_rdata = aux_q;
    if (sel_q == RG_TBL) begin
      case (word_q)
        2'd0:    reg_rdata = sw_q[0];
        2'd1:    reg_rdata = sw_q[1];
        default: reg_rdata = sw_q[2];
      endcase
    end
  end

  // ---------------- assertions ----------------
  a_r3_reset_state: assert property (@(posedge clk)
    $fell(rst) |-> (&mask_q) && (pend_q == '0) && !msg_valid);

  a_r4_no_masked_pick: assert property (@(posedge clk) disable iff (rst)
    pick_vld |-> !fn_mask && !mask_q[pick_idx]);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  a_r10_single_flight: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !fetch_q);

  a_r12_launch_needs_en: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_q) |-> $past(msix_en));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
    a_r5_no_stray_pend: assert property (@(posedge clk) disable iff (rst)
      !pend_q[v] && !(req_vld && req_idx == MSIX_IDX_W'(v) && msix_en && vec_inuse[v])
      |=> !pend_q[v]);
  end
endmodule

// File: tb/msix_vec_ctrl_test.sv
module msix_vec_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msix_en = 1'b0, fn_mask = 1'b0;
  logic [N-1:0] vec_inuse = 8'h7F;
  logic        req_vld = 1'b0;
  logic [10:0] req_idx = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string phase = "R3";
  logic [31:0] acc_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  msix_vec_ctrl #(.NUM_VEC(N), .ADDR_W(12)) uut (
    .clk(clk), .rst(rst), .msix_en(msix_en), .fn_mask(fn_mask),
    .vec_inuse(vec_inuse), .req_vld(req_vld), .req_idx(req_idx),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_pend [N];
  bit          m_mask [N];
  logic [31:0] m_lo [N], m_hi [N], m_dat [N];
  int          m_fetch, m_pick;
  bit          m_ov, m_rdchk;
  logic [63:0] m_fa, m_oa;
  logic [31:0] m_fd, m_od, m_erd;

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int ia, v;
    logic [31:0] r;
    ia = int'(a);
    r = '0;
    if (ia < N * 16) begin
      v = ia / 16;
      case ((ia / 4) % 4)
        0: r = m_lo[v];
        1: r = m_hi[v];
        2: r = m_dat[v];
        default: r = {31'b0, m_mask[v]};
      endcase
    end else if (ia >= 2048 && ia < 2052) begin
      for (int b = 0; b < N; b++) r[b] = m_pend[b];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < N; v++) begin m_pend[v] = 0; m_mask[v] = 1; end
      m_fetch = -1; m_ov = 0; m_rdchk = 0;
    end else begin
      m_rdchk = reg_rd;
      if (reg_rd) m_erd = model_read(reg_addr);
      m_pick = -1;
      if (msix_en && m_fetch < 0 && !m_ov) begin
        for (int v = N - 1; v >= 0; v--)
          if (m_pend[v] && !(fn_mask || m_mask[v])) m_pick = v;
      end
      if (m_ov && msg_ready) m_ov = 0;
      if (m_fetch >= 0) begin m_ov = 1; m_oa = m_fa; m_od = m_fd; end
      m_fetch = m_pick;
      if (m_pick >= 0) begin
        m_pend[m_pick] = 0;
        m_fa = {m_hi[m_pick], m_lo[m_pick]};
        m_fd = m_dat[m_pick];
      end
      if (reg_wr && int'(reg_addr) < N * 16) begin
        case ((int'(reg_addr) / 4) % 4)
          0: m_lo[int'(reg_addr) / 16] = reg_wdata;
          1: m_hi[int'(reg_addr) / 16] = reg_wdata;
          2: m_dat[int'(reg_addr) / 16] = reg_wdata;
          default: m_mask[int'(reg_addr) / 16] = reg_wdata[0];
        endcase
      end
      if (req_vld && msix_en && req_idx < 11'(N)) begin
        if (vec_inuse[req_idx[2:0]]) m_pend[req_idx[2:0]] = 1;
      end
      if (msg_valid && msg_ready) acc_q.push_back(msg_data);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check({phase, " R10 msg_valid vs model"}, 64'(msg_valid), 64'(m_ov));
      if (m_ov) begin
        check({phase, " R7 msg_addr vs model"}, msg_addr, m_oa);
        check({phase, " R7 msg_data vs model"}, 64'(msg_data), 64'(m_od));
      end
      if (m_rdchk) check({phase, " R13 read data vs model"}, 64'(reg_rdata), 64'(m_erd));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1; reg_addr = 12'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_rd = 1; reg_addr = 12'(a);
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic req(input int i);
    req_vld = 1; req_idx = 11'(i);
    @(negedge clk);
    req_vld = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;

    // R3: reset state
    phase = "R3";
    rd(12, d);   check("R3 vec0 mask after reset", 64'(d), 64'd1);
    rd(7*16+12, d); check("R3 vec7 mask after reset", 64'(d), 64'd1);
    rd(2048, d); check("R1 R3 bitmap at offset 2048 empty", 64'(d), 64'd0);
    check("R3 msg_valid low", 64'(msg_valid), 64'd0);

    // R2: program table
    phase = "R2";
    for (int v = 0; v < N; v++) begin
      wr(v*16 + 0, 32'h1000_0000 + 32'(v*16));
      wr(v*16 + 4, 32'h0000_00A0 + 32'(v));
      wr(v*16 + 8, 32'(v));
    end
    wr(16+12, 32'hFFFF_FFFF);
    rd(16+12, d);  check("R2 ctrl keeps only bit 0", 64'(d), 64'd1);
    rd(3*16+1, d); check("R2 low addr bits ignored", 64'(d), 64'h1000_0030);
    rd(5*16+6, d); check("R2 address high word", 64'(d), 64'hA5);
    for (int v = 0; v < N; v++) wr(v*16+12, 32'hFFFF_FFFE);
    rd(16+12, d);  check("R2 ctrl unmask", 64'(d), 64'd0);

    // R12: disabled requests are not latched
    phase = "R12";
    req(1); idle(4);
    check("R12 no message while disabled", 64'(msg_valid), 64'd0);
    rd(2048, d); check("R12 no pending while disabled", 64'(d), 64'd0);

    // R7: delivery latency and payload
    phase = "R7";
    msix_en = 1;
    req(3);
    check("R7 not valid after request edge", 64'(msg_valid), 64'd0);
    idle(1);
    check("R7 not valid after pick edge", 64'(msg_valid), 64'd0);
    idle(1);
    check("R7 valid two edges after request", 64'(msg_valid), 64'd1);
    check("R7 address of vector 3", msg_addr, 64'h0000_00A3_1000_0030);
    check("R7 data of vector 3", 64'(msg_data), 64'd3);
    idle(2);

    // R5: dropped requests
    phase = "R5";
    req(7); req(8); req(2047); idle(4);
    rd(2048, d); check("R5 ignored requests leave bitmap clear", 64'(d), 64'd0);
    check("R5 ignored requests send nothing", 64'(msg_valid), 64'd0);

    // R4 R6: masked requests go pending
    phase = "R6";
    acc_q.delete();
    wr(4*16+12, 32'd1);
    req(4); idle(4);
    check("R6 entry-masked request sends nothing", 64'(msg_valid), 64'd0);
    rd(2048, d); check("R6 vector 4 pending bit 4", 64'(d), 64'h10);
    fn_mask = 1;
    req(2); idle(4);
    rd(2048, d); check("R4 function mask makes vector 2 pending", 64'(d), 64'h14);

    // R8: unmask delivers
    phase = "R8";
    fn_mask = 0; idle(5);
    rd(2048, d); check("R8 vector 2 drained by fn_mask clear", 64'(d), 64'h10);
    wr(4*16+12, 32'd0); idle(5);
    rd(2048, d); check("R8 vector 4 drained by entry unmask", 64'(d), 64'd0);
    check("R8 two messages delivered", 64'(acc_q.size()), 64'd2);
    if (acc_q.size() == 2) begin
      check("R8 first delivered is vector 2", 64'(acc_q[0]), 64'd2);
      check("R8 second delivered is vector 4", 64'(acc_q[1]), 64'd4);
    end

    // R9 R10: priority and backpressure
    phase = "R9";
    acc_q.delete();
    msg_ready = 0; fn_mask = 1;
    req(5); req(2); req(6);
    fn_mask = 0; idle(5);
    check("R10 message presented under backpressure", 64'(msg_valid), 64'd1);
    check("R9 lowest vector first", 64'(msg_data), 64'd2);
    idle(3);
    check("R10 payload held while not ready", 64'(msg_data), 64'd2);
    msg_ready = 1; idle(12);
    check("R9 three messages", 64'(acc_q.size()), 64'd3);
    if (acc_q.size() == 3) begin
      check("R9 order slot 0", 64'(acc_q[0]), 64'd2);
      check("R9 order slot 1", 64'(acc_q[1]), 64'd5);
      check("R9 order slot 2", 64'(acc_q[2]), 64'd6);
    end

    // R11: bitmap writes ignored
    phase = "R11";
    wr(12, 32'd1);
    req(0); idle(3);
    wr(2048, 32'd0);
    rd(2048, d); check("R11 write of zero ignored", 64'(d), 64'd1);
    wr(2048, 32'hFF);
    rd(2048, d); check("R11 write of ones ignored", 64'(d), 64'd1);
    wr(12, 32'd0); idle(5);
    rd(2048, d); check("R11 drained after unmask", 64'(d), 64'd0);

    // R13: reads outside both regions
    phase = "R13";
    rd(12'h400, d); check("R13 hole reads zero", 64'(d), 64'd0);
    rd(12'hFFC, d); check("R13 top of window reads zero", 64'(d), 64'd0);

    // R12: pending kept across disable
    phase = "R12";
    acc_q.delete();
    wr(16+12, 32'd1);
    req(1); idle(2);
    msix_en = 0;
    wr(16+12, 32'd0); idle(5);
    check("R12 no launch while disabled", 64'(msg_valid), 64'd0);
    rd(2048, d); check("R12 pending kept while disabled", 64'(d), 64'h2);
    msix_en = 1; idle(5);
    rd(2048, d); check("R12 delivered after enable", 64'(d), 64'd0);
    check("R12 one message after enable", 64'(acc_q.size()), 64'd1);
    if (acc_q.size() == 1) check("R12 message is vector 1", 64'(acc_q[0]), 64'd1);

    idle(3);
    finish_run();
  end
endmodule